// File: doc/BRIEF.md
# Backward Branch Loop Profiler

This block sits beside a processor and listens to its instruction-fetch address stream without ever driving anything back to the processor. Whenever the next fetched address falls below the previous one, and is neither a repeat of it nor its sequential successor, the previous address is taken as a loop-closing branch and the new address as that loop's start. Such a back-edge is logged in a small fully associative table that holds the branch address, the loop start and a saturating execution count for each entry.

A partitioning engine or software finds the hottest loop by pulsing a query strobe. One cycle later the block returns the table slot, branch address, loop start and count of the entry that has the largest count. When a table miss arrives and every slot is in use, the coldest entry is evicted. A counter that would overflow makes every count halve at once, so the ranking keeps its order instead of piling up at the ceiling. A synchronous clear empties the table.

Top module: `loop_profiler`

## Requirements
- R1: A back-edge is recognised on an accepted fetch (fetch_valid high) only when an earlier fetch since reset or clear exists and the new address is below it, differs from it and differs from it plus 4 (modulo 2^32). The earlier address becomes the branch, the new one the loop start. Repeated, sequential (including 0xFFFFFFFC to 0x0) and upward fetches record nothing.
- R2: A back-edge whose branch address matches a valid entry adds one to that entry's count and replaces its stored loop start with the new one.
- R3: A back-edge that matches no entry, while a free slot exists, fills the lowest-numbered free slot with count 1.
- R4: A back-edge that matches no entry while all N slots are valid overwrites the slot with the smallest count (lowest slot number on a tie) and gives it count 1.
- R5: A hit on an entry whose count equals 2^CNT_W-1 sets that entry to 2^(CNT_W-1) and, on the same edge, halves (rounding down) every other count.
- R6: A query strobe sampled at a clock edge yields rsp_valid high for exactly the following cycle, carrying the entry with the largest count as the table stood just before that edge; ties go to the lowest slot number.
- R7: When no entry is valid, the response has rsp_hit low and rsp_index, rsp_branch, rsp_target and rsp_count all zero.
- R8: clear empties the table and forgets the previous fetch address; a fetch presented in the same cycle as clear is ignored.
- R9: After reset the table is empty and no previous fetch address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous table flush |
| fetch_valid | input | 1 | A fetch address is present this cycle |
| fetch_addr | input | 32 | Instruction-fetch address |
| query | input | 1 | Request the hottest entry |
| rsp_valid | output | 1 | Response present, one cycle after query |
| rsp_hit | output | 1 | The table held at least one entry |
| rsp_index | output | $clog2(N) | Slot of the hottest entry |
| rsp_branch | output | 32 | Branch address of the hottest entry |
| rsp_target | output | 32 | Loop start of the hottest entry |
| rsp_count | output | CNT_W | Count of the hottest entry |

## Verification
A table of loops with different repetition counts checks that counting ranks them correctly, that a later tie does not displace the earlier slot, and that a hit with a new loop start rewrites only the target. Streams of repeats, steps of four, upward jumps and the wrap from the top of the address space separate a true back-edge from a mere address change. Filling all slots with one deliberately cold entry and then adding a new loop shows which slot is evicted. A counter driven to its ceiling, followed by a catch-up on a second loop, shows that the other counts were halved rather than left alone.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int ADDR_W = 32;
  localparam logic [ADDR_W-1:0] INSN_BYTES = 32'd4;

  // Sequential successor of a fetch address (wraps at the top of the space).
  function automatic logic [ADDR_W-1:0] next_seq(input logic [ADDR_W-1:0] a);
    return a + INSN_BYTES;
  endfunction

  // A downward discontinuity in the fetch stream marks a loop back-edge.
  function automatic logic is_back_edge(input logic [ADDR_W-1:0] prev,
                                        input logic [ADDR_W-1:0] cur);
    return (cur < prev) && (cur != prev) && (cur != next_seq(prev));
  endfunction
endpackage

// File: rtl/lp_edge_detect.sv
module lp_edge_detect
  import lp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              edge_fire,
  output logic [ADDR_W-1:0] edge_branch,
  output logic [ADDR_W-1:0] edge_target
);
  logic              prev_vld;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      prev_vld  <= 1'b0;
      prev_addr <= '0;
    end else if (fetch_valid) begin
      prev_vld  <= 1'b1;
      prev_addr <= fetch_addr;
    end
  end

  assign edge_fire   = fetch_valid && prev_vld && is_back_edge(prev_addr, fetch_addr);
  assign edge_branch = prev_addr;
  assign edge_target = fetch_addr;
endmodule

// File: rtl/lp_rank.sv
module lp_rank #(
  parameter int N        = 16,
  parameter int CNT_W    = 16,
  parameter bit PICK_MAX = 1'b1
) (
  input  logic [N-1:0]       vld,
  input  logic [N*CNT_W-1:0] cnt_flat,
  output logic               best_any,
  output logic [$clog2(N)-1:0] best_idx,
  output logic [CNT_W-1:0]   best_val
);
  localparam int IW = $clog2(N);

  if (PICK_MAX) begin : g_max
    always_comb begin
      best_any = 1'b0;
      best_idx = '0;
      best_val = '0;
      for (int i = 0; i < N; i++) begin
        if (vld[i] && (!best_any || cnt_flat[i*CNT_W +: CNT_W] > best_val)) begin
          best_any = 1'b1;
          best_idx = IW'(i);
          best_val = cnt_flat[i*CNT_W +: CNT_W];
        end
      end
    end
  end else begin : g_min
    always_comb begin
      best_any = 1'b0;
      best_idx = '0;
      best_val = '0;
      for (int i = 0; i < N; i++) begin
        if (vld[i] && (!best_any || cnt_flat[i*CNT_W +: CNT_W] < best_val)) begin
          best_any = 1'b1;
          best_idx = IW'(i);
          best_val = cnt_flat[i*CNT_W +: CNT_W];
        end
      end
    end
  end
endmodule

// File: rtl/loop_profiler.sv
module loop_profiler
  import lp_pkg::*;
#(
  parameter int N     = 16,
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 fetch_valid,
  input  logic [31:0]          fetch_addr,
  input  logic                 query,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [$clog2(N)-1:0] rsp_index,
  output logic [31:0]          rsp_branch,
  output logic [31:0]          rsp_target,
  output logic [CNT_W-1:0]     rsp_count
);
  localparam int IW = $clog2(N);
  localparam logic [CNT_W-1:0] CNT_TOP  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(1) << (CNT_W-1);

  function automatic logic [CNT_W-1:0] halve_cnt(input logic [CNT_W-1:0] c);
    return c >> 1;
  endfunction

  // Back-edge detection
  logic              edge_fire;
  logic [ADDR_W-1:0] edge_br, edge_tg;

  lp_edge_detect u_det (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .edge_fire(edge_fire), .edge_branch(edge_br), .edge_target(edge_tg)
  );

  // Table storage
  logic [N-1:0]       vld_q;
  logic [ADDR_W-1:0]  br_q  [N];
  logic [ADDR_W-1:0]  tg_q  [N];
  logic [CNT_W-1:0]   cnt_q [N];
  logic [N*CNT_W-1:0] cnt_flat;

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q[g];
  end

  // Associative lookup and free-slot search
  logic          hit_any, free_any;
  logic [IW-1:0] hit_idx, free_idx;

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && br_q[i] == edge_br && !hit_any) begin
        hit_any = 1'b1;
        hit_idx = IW'(i);
      end
      if (!vld_q[i] && !free_any) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  // Ranking: coldest slot for eviction, hottest slot for readout
  logic             min_any, max_any;
  logic [IW-1:0]    min_idx, max_idx;
  logic [CNT_W-1:0] min_cnt, max_cnt;

  lp_rank #(.N(N), .CNT_W(CNT_W), .PICK_MAX(1'b0)) u_coldest (
    .vld(vld_q), .cnt_flat(cnt_flat),
    .best_any(min_any), .best_idx(min_idx), .best_val(min_cnt)
  );

  lp_rank #(.N(N), .CNT_W(CNT_W), .PICK_MAX(1'b1)) u_hottest (
    .vld(vld_q), .cnt_flat(cnt_flat),
    .best_any(max_any), .best_idx(max_idx), .best_val(max_cnt)
  );

  // Named events for the checker
  logic          bb_fire, sat_evt, alloc_evt, full;
  logic [IW-1:0] alloc_slot;

  assign bb_fire    = edge_fire && !clear;
  assign full       = &vld_q;
  assign sat_evt    = bb_fire && hit_any && (cnt_q[hit_idx] == CNT_TOP);
  assign alloc_evt  = bb_fire && !hit_any;
  assign alloc_slot = free_any ? free_idx : min_idx;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        br_q[i]  <= '0;
        tg_q[i]  <= '0;
        cnt_q[i] <= '0;
      end
    end else if (bb_fire) begin
      if (hit_any) begin
        tg_q[hit_idx] <= edge_tg;
        if (sat_evt) begin
          for (int i = 0; i < N; i++) cnt_q[i] <= halve_cnt(cnt_q[i]);
          cnt_q[hit_idx] <= CNT_HALF;
        end else begin
          cnt_q[hit_idx] <= cnt_q[hit_idx] + 1'b1;
        end
      end else if (alloc_evt) begin
        vld_q[alloc_slot] <= 1'b1;
        br_q[alloc_slot]  <= edge_br;
        tg_q[alloc_slot]  <= edge_tg;
        cnt_q[alloc_slot] <= CNT_W'(1);
      end
    end
  end

  // Query response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_index  <= '0;
      rsp_branch <= '0;
      rsp_target <= '0;
      rsp_count  <= '0;
    end else begin
      rsp_valid <= query;
      if (query) begin
        rsp_hit    <= max_any;
        rsp_index  <= max_any ? max_idx : '0;
        rsp_branch <= max_any ? br_q[max_idx] : '0;
        rsp_target <= max_any ? tg_q[max_idx] : '0;
        rsp_count  <= max_any ? max_cnt : '0;
      end
    end
  end
endmodule

// File: rtl/lp_checker.sv
module lp_checker #(
  parameter int N     = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic             query,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [CNT_W-1:0] rsp_count,
  input logic [N-1:0]     vld,
  input logic             full,
  input logic             bb_fire,
  input logic             hit_any,
  input logic             sat_evt,
  input logic [CNT_W-1:0] max_cnt
);
  localparam logic [CNT_W-1:0] HALF_PLUS = CNT_W'(1) << (CNT_W-1);

  assert_rsp_follows_query_R6: assert property (@(posedge clk) disable iff (!rst_n)
    query |=> rsp_valid);

  assert_rsp_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !query |=> !rsp_valid);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vld == '0));

  assert_quiet_without_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!bb_fire && !clear) |=> ($stable(vld) && $stable(max_cnt)));

  assert_alloc_adds_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_fire && !hit_any && !full) |=> ($countones(vld) == $past($countones(vld)) + 1));

  assert_evict_keeps_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bb_fire && !hit_any && full) |=> (vld == '1));

  assert_sat_rescales_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_evt && !clear) |=> (max_cnt == HALF_PLUS));

  assert_hit_count_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_count != '0));
endmodule

bind loop_profiler lp_checker #(.N(N), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .query(query),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_count(rsp_count),
  .vld(vld_q), .full(full), .bb_fire(bb_fire), .hit_any(hit_any),
  .sat_evt(sat_evt), .max_cnt(max_cnt)
);

// File: tb/loop_profiler_tb_top.sv
`timescale 1ns/1ps
module loop_profiler_tb_top;
  localparam int N  = 16;
  localparam int CW = 6;   // short counters keep the saturation test fast

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [31:0]   fetch_addr = '0;
  logic          query = 1'b0;
  logic          rsp_valid, rsp_hit;
  logic [3:0]    rsp_index;
  logic [31:0]   rsp_branch, rsp_target;
  logic [CW-1:0] rsp_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  loop_profiler #(.N(N), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .query(query),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_index(rsp_index),
    .rsp_branch(rsp_branch), .rsp_target(rsp_target), .rsp_count(rsp_count)
  );

  typedef struct packed {
    logic [31:0] br;
    logic [31:0] tg;
    int          reps;
    int          eidx;
    logic [31:0] ebr;
    logic [31:0] etg;
    int          ecnt;
  } row_t;

  // Each row runs one loop, then the hottest entry is queried.
  localparam row_t ROWS [6] = '{
    '{32'h100, 32'h0F0, 5, 0, 32'h100, 32'h0F0, 5},
    '{32'h200, 32'h1C0, 7, 1, 32'h200, 32'h1C0, 7},
    '{32'h300, 32'h2F8, 3, 1, 32'h200, 32'h1C0, 7},
    '{32'h400, 32'h3E0, 7, 1, 32'h200, 32'h1C0, 7},  // tie keeps lower slot
    '{32'h500, 32'h480, 2, 1, 32'h200, 32'h1C0, 7},
    '{32'h200, 32'h1A0, 1, 1, 32'h200, 32'h1A0, 8}   // hit rewrites loop start
  };

  task automatic fetch(input logic [31:0] a);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
  endtask

  task automatic run_loop(input logic [31:0] br, input logic [31:0] tg, input int n);
    for (int k = 0; k < n; k++) begin
      fetch(br);
      fetch(tg);
    end
  endtask

  task automatic do_query();
    @(negedge clk);
    fetch_valid = 1'b0;
    query = 1'b1;
    @(negedge clk);
    query = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    fetch_valid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input bit ehit, input int eidx,
                            input logic [31:0] ebr, input logic [31:0] etg, input int ecnt);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== ehit || rsp_index !== 4'(eidx) ||
        rsp_branch !== ebr || rsp_target !== etg || rsp_count !== CW'(ecnt)) begin
      fails++;
      $display("FAIL %s: got v=%0b hit=%0b idx=%0d br=%h tg=%h cnt=%0d exp v=1 hit=%0b idx=%0d br=%h tg=%h cnt=%0d",
               req, rsp_valid, rsp_hit, rsp_index, rsp_branch, rsp_target, rsp_count,
               ehit, eidx, ebr, etg, ecnt);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: empty after reset (R7 zeroed fields)
    do_query();
    expect_rsp("R9", 1'b0, 0, 32'h0, 32'h0, 0);
    // R6: response lasts a single cycle
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R6: got rsp_valid=%0b exp 0", rsp_valid);
    end

    // Table walk: R1 detection, R2 counting, R3 allocation, R6 ranking
    for (int r = 0; r < 6; r++) begin
      run_loop(ROWS[r].br, ROWS[r].tg, ROWS[r].reps);
      do_query();
      expect_rsp($sformatf("R2/R6 row %0d", r), 1'b1, ROWS[r].eidx,
                 ROWS[r].ebr, ROWS[r].etg, ROWS[r].ecnt);
    end

    // R8: clear empties the table
    do_clear();
    do_query();
    expect_rsp("R8", 1'b0, 0, 32'h0, 32'h0, 0);

    // R8: fetch during clear is ignored, previous address forgotten
    fetch(32'h900);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = 32'h800;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    fetch_valid = 1'b1;
    fetch_addr  = 32'h700;
    do_query();
    expect_rsp("R8", 1'b0, 0, 32'h0, 32'h0, 0);
    fetch(32'h600);
    do_query();
    expect_rsp("R8", 1'b1, 0, 32'h700, 32'h600, 1);
    do_clear();

    // R1: repeats, steps of four, upward jumps and address wrap record nothing
    fetch(32'h1000);
    fetch(32'h1004);
    fetch(32'h1004);
    fetch(32'h1020);
    fetch(32'hFFFF_FFFC);
    fetch(32'h0);
    do_query();
    expect_rsp("R1", 1'b0, 0, 32'h0, 32'h0, 0);
    do_clear();

    // R3: fill every slot, slot 5 kept coldest
    for (int i = 0; i < N; i++)
      run_loop(32'h2000 + 32'(i) * 32'h40, 32'h1FE0 + 32'(i) * 32'h40, (i == 5) ? 1 : 2);
    do_query();
    expect_rsp("R3", 1'b1, 0, 32'h2000, 32'h1FE0, 2);
    // R4: a new loop evicts the coldest slot
    run_loop(32'h3000, 32'h2FE0, 4);
    do_query();
    expect_rsp("R4", 1'b1, 5, 32'h3000, 32'h2FE0, 4);
    do_clear();

    // R5: saturation halves the others
    run_loop(32'h4000, 32'h3F00, 10);
    run_loop(32'h5000, 32'h4F00, 63);
    do_query();
    expect_rsp("R2", 1'b1, 1, 32'h5000, 32'h4F00, 63);
    run_loop(32'h5000, 32'h4F00, 1);
    do_query();
    expect_rsp("R5", 1'b1, 1, 32'h5000, 32'h4F00, 32);
    run_loop(32'h4000, 32'h3F00, 27);   // 10/2 + 27 = 32 ties, lower slot wins
    do_query();
    expect_rsp("R5", 1'b1, 0, 32'h4000, 32'h3F00, 32);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule